// File: doc/BRIEF.md
# Two-Level Function Memory Translation Walker

This block maps a guest offset into a host local-memory address. A requester, identified by a virtual-function number, supplies the offset. The block walks two tables held in memory, one read at a time. The first read fetches a 32-bit root entry chosen by the function number, starting from a configured root base. If that entry is valid, it points at a leaf table aligned to 64 KB. The second read fetches the 32-bit leaf entry chosen by the 2 MB page index of the guest offset. If that entry is valid, it supplies the host page number. The host page number is combined with the offset within the page to form the result.

Requests and responses use valid/ready handshakes. The block handles one translation at a time. A walk that cannot complete returns a fault code instead of an address. Such a walk issues no memory read beyond the step that failed.

Top module: `vf_mem_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_valid` is 0.
- R2: The first read of a walk goes to `root_base + 4*fid`.
- R3: The second read goes to `(P << 16) + 4*((gofs >> 21) mod 2^(HAW-21))`, modulo 2^HAW. P is bits HAW-13..4 of the root entry.
- R4: A successful walk answers code 0 with `rsp_haddr = (G << 21) | gofs[20:0]`. G is bits HAW-17..5 of the leaf entry.
- R5: A request for function 0 answers code 2 and performs no memory read.
- R6: A guest offset with any bit at or above HAW set answers code 1 and performs no memory read. This check takes precedence over the function-0 check.
- R7: A root entry with bit 0 clear answers code 3 after exactly one read.
- R8: A leaf entry with bit 0 clear answers code 4 after exactly two reads.
- R9: Every fault response (code not 0) carries `rsp_haddr` equal to 0.
- R10: Bits 3..1 and 31..HAW-12 of a root entry do not change the result. Bits 4..1 and 31..HAW-16 of a leaf entry do not change the result.
- R11: `req_ready` stays 0 from acceptance until the response is taken. While `rsp_ready` is 0, the response stays valid and unchanged.
- R12: While `mem_rd_valid` is 1 and `mem_rd_dvalid` is 0, the read address stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | HAW | Byte address of the root table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_fid | input | FID_W | Function number |
| req_gofs | input | GOFS_W | Guest byte offset |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_code | output | 3 | 0 ok, 1 out of range, 2 function 0, 3 root invalid, 4 leaf invalid |
| rsp_haddr | output | HAW | Host byte address (0 on fault) |
| mem_rd_valid | output | 1 | Read request outstanding |
| mem_rd_addr | output | HAW | Read byte address |
| mem_rd_dvalid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |

## Verification
The walk is tried with these inputs:
- A mid-range function and page, which shows that the root and leaf index computations are separate.
- The highest function number with an all-ones offset, which exercises the top of both index ranges.
- Entries filled with reserved ones, which separates field extraction from whole-word use.

Each fault cause is provoked on its own and counted by the number of reads issued. An out-of-range offset is also combined with function 0 to fix their precedence. A second function mapped to a different table shows that the per-function root entry, not leftover state, selects the leaf table.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
  localparam int PAGE_SH = 21;
  localparam int TBL_SH  = 16;

  typedef enum logic [2:0] {
    XL_OK       = 3'd0,
    XL_RANGE    = 3'd1,
    XL_FID0     = 3'd2,
    XL_ROOT_INV = 3'd3,
    XL_LEAF_INV = 3'd4
  } xl_code_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK,
    S_ROOT,
    S_LEAF,
    S_RESP
  } walk_st_e;
endpackage

// File: rtl/vfw_entry_dec.sv
// Field extraction for a fetched 32-bit table word (root or leaf view).
module vfw_entry_dec #(
  parameter int HAW = 37
) (
  input  logic [31:0]      ent,
  output logic             vld,
  output logic [HAW-17:0]  tbl_ptr,
  output logic [HAW-22:0]  page
);
  assign vld     = ent[0];
  assign tbl_ptr = ent[HAW-13:4];
  assign page    = ent[HAW-17:5];

  // reserved fields are dropped on purpose
  logic unused_rsvd;
  assign unused_rsvd = ^{ent[31:HAW-12], ent[3:1]};
endmodule

// File: rtl/vfw_addr_gen.sv
// Address arithmetic for both walk steps and the final host address.
module vfw_addr_gen #(
  parameter int HAW    = 37,
  parameter int FID_W  = 6,
  parameter int GOFS_W = 40
) (
  input  logic [HAW-1:0]    root_base,
  input  logic [FID_W-1:0]  fid,
  input  logic [GOFS_W-1:0] gofs,
  input  logic [HAW-17:0]   tbl_ptr,
  input  logic [HAW-22:0]   page,
  output logic [HAW-1:0]    root_addr,
  output logic [HAW-1:0]    leaf_addr,
  output logic [HAW-1:0]    host_addr,
  output logic              range_bad
);
  localparam int IDX_W = HAW - vfw_pkg::PAGE_SH;

  logic [IDX_W-1:0] leaf_idx;
  assign leaf_idx  = gofs[HAW-1:vfw_pkg::PAGE_SH];

  assign root_addr = root_base + HAW'({fid, 2'b00});
  assign leaf_addr = {tbl_ptr, {vfw_pkg::TBL_SH{1'b0}}} + HAW'({leaf_idx, 2'b00});
  assign host_addr = {page, gofs[vfw_pkg::PAGE_SH-1:0]};

  generate
    if (GOFS_W > HAW) begin : g_range
      assign range_bad = |gofs[GOFS_W-1:HAW];
    end else begin : g_norange
      assign range_bad = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/vf_mem_walker.sv
module vf_mem_walker #(
  parameter int HAW    = 37,
  parameter int FID_W  = 6,
  parameter int GOFS_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HAW-1:0]    root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FID_W-1:0]  req_fid,
  input  logic [GOFS_W-1:0] req_gofs,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [HAW-1:0]    rsp_haddr,
  output logic              mem_rd_valid,
  output logic [HAW-1:0]    mem_rd_addr,
  input  logic              mem_rd_dvalid,
  input  logic [31:0]       mem_rd_data
);
  import vfw_pkg::*;

  walk_st_e          st;
  logic [FID_W-1:0]  fid_q;
  logic [GOFS_W-1:0] gofs_q;
  xl_code_e          code_q;

  logic              ent_vld;
  logic [HAW-17:0]   ent_ptr;
  logic [HAW-22:0]   ent_page;
  logic [HAW-1:0]    root_addr, leaf_addr, host_addr;
  logic              range_bad;

  vfw_entry_dec #(.HAW(HAW)) u_dec (
    .ent     (mem_rd_data),
    .vld     (ent_vld),
    .tbl_ptr (ent_ptr),
    .page    (ent_page)
  );

  vfw_addr_gen #(.HAW(HAW), .FID_W(FID_W), .GOFS_W(GOFS_W)) u_agen (
    .root_base (root_base),
    .fid       (fid_q),
    .gofs      (gofs_q),
    .tbl_ptr   (ent_ptr),
    .page      (ent_page),
    .root_addr (root_addr),
    .leaf_addr (leaf_addr),
    .host_addr (host_addr),
    .range_bad (range_bad)
  );

  assign rsp_code = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      req_ready    <= 1'b1;
      rsp_valid    <= 1'b0;
      code_q       <= XL_OK;
      rsp_haddr    <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      fid_q        <= '0;
      gofs_q       <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            fid_q     <= req_fid;
            gofs_q    <= req_gofs;
            req_ready <= 1'b0;
            st        <= S_CHK;
          end
        end
        S_CHK: begin
          if (range_bad) begin
            rsp_valid <= 1'b1;
            code_q    <= XL_RANGE;
            rsp_haddr <= '0;
            st        <= S_RESP;
          end else if (fid_q == '0) begin
            rsp_valid <= 1'b1;
            code_q    <= XL_FID0;
            rsp_haddr <= '0;
            st        <= S_RESP;
          end else begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= root_addr;
            st           <= S_ROOT;
          end
        end
        S_ROOT: begin
          if (mem_rd_dvalid) begin
            if (!ent_vld) begin
              mem_rd_valid <= 1'b0;
              rsp_valid    <= 1'b1;
              code_q       <= XL_ROOT_INV;
              rsp_haddr    <= '0;
              st           <= S_RESP;
            end else begin
              mem_rd_addr <= leaf_addr;
              st          <= S_LEAF;
            end
          end
        end
        S_LEAF: begin
          if (mem_rd_dvalid) begin
            mem_rd_valid <= 1'b0;
            rsp_valid    <= 1'b1;
            code_q       <= ent_vld ? XL_OK : XL_LEAF_INV;
            rsp_haddr    <= ent_vld ? host_addr : '0;
            st           <= S_RESP;
          end
        end
        S_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            req_ready <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: response held until taken
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_haddr) && $stable(rsp_code));

  // R11: no new request while a walk or response is pending
  a_r11_busy: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid && !mem_rd_valid);

  // R12: read address stable while waiting
  a_r12_addr_hold: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_dvalid |=> mem_rd_valid && $stable(mem_rd_addr));

  // R7: invalid root entry ends the walk without a second read
  a_r7_root_stop: assert property (@(posedge clk) disable iff (rst)
    (st == S_ROOT) && mem_rd_dvalid && !mem_rd_data[0] |=>
      !mem_rd_valid && rsp_valid && (rsp_code == 3'd3));

  // R9: fault responses carry a zero address
  a_r9_fault_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_code != 3'd0) |-> rsp_haddr == '0);
endmodule

// File: tb/vf_mem_walker_tb_top.sv
`timescale 1ns/1ps
module vf_mem_walker_tb_top;
  localparam int HAW = 37;
  localparam int FID_W = 6;
  localparam int GOFS_W = 40;
  localparam logic [HAW-1:0] RBASE = 37'h00_0010_0000;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, rsp_valid, rsp_ready;
  logic [FID_W-1:0] req_fid;
  logic [GOFS_W-1:0] req_gofs;
  logic [2:0] rsp_code;
  logic [HAW-1:0] rsp_haddr;
  logic mem_rd_valid, mem_rd_dvalid;
  logic [HAW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data;

  always #2.5 clk = ~clk;

  vf_mem_walker #(.HAW(HAW), .FID_W(FID_W), .GOFS_W(GOFS_W)) dut_i (
    .clk(clk), .rst(rst), .root_base(RBASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_fid(req_fid), .req_gofs(req_gofs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_haddr(rsp_haddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_dvalid(mem_rd_dvalid), .mem_rd_data(mem_rd_data)
  );

  // sparse memory model, fixed latency
  logic [31:0] mem_img [logic [HAW-1:0]];
  int lat_cnt = 0;
  int rd_cnt = 0;
  logic [HAW-1:0] rd_log [16];
  int mon_bad = 0;
  logic prev_wait = 1'b0;
  logic [HAW-1:0] prev_addr = '0;

  initial begin
    mem_rd_dvalid = 1'b0;
    mem_rd_data = '0;
  end

  always @(posedge clk) begin
    if (mem_rd_valid && !mem_rd_dvalid) begin
      if (lat_cnt == 2) begin
        mem_rd_dvalid <= 1'b1;
        mem_rd_data <= mem_img.exists(mem_rd_addr) ? mem_img[mem_rd_addr] : 32'h0;
        lat_cnt <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else begin
      mem_rd_dvalid <= 1'b0;
      lat_cnt <= 0;
    end
    if (mem_rd_valid && mem_rd_dvalid) begin
      rd_log[rd_cnt % 16] <= mem_rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
    prev_wait <= mem_rd_valid && !mem_rd_dvalid;
    prev_addr <= mem_rd_addr;
    if (prev_wait && (!mem_rd_valid || mem_rd_addr != prev_addr)) mon_bad <= mon_bad + 1;
  end

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] root_ent(input logic [HAW-17:0] p, input bit v);
    return 32'(p) << 4 | 32'(v);
  endfunction

  function automatic logic [31:0] leaf_ent(input logic [HAW-22:0] g, input bit v);
    return 32'(g) << 5 | 32'(v);
  endfunction

  function automatic logic [HAW-1:0] exp_leaf(input logic [HAW-17:0] p, input logic [GOFS_W-1:0] o);
    return HAW'({p, 16'h0}) + HAW'(((o >> 21) & 40'hFFFF) * 4);
  endfunction

  // one transaction; checks R11 handshake behaviour on the way
  task automatic do_req(input logic [FID_W-1:0] fid, input logic [GOFS_W-1:0] ofs,
                        output logic [2:0] code, output logic [HAW-1:0] ha, output int nrd);
    int base;
    int w;
    base = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_fid = fid; req_gofs = ofs;
    w = 0;
    while (!req_ready && w < 200) begin @(negedge clk); w++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 busy after accept", 64'(req_ready), 64'd0);
    w = 0;
    while (!rsp_valid && w < 200) begin @(negedge clk); w++; end
    chk(rsp_valid, "R11 response arrives", 64'(rsp_valid), 64'd1);
    code = rsp_code; ha = rsp_haddr;
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_code == code && rsp_haddr == ha, "R11 response held",
        64'(rsp_haddr), 64'(ha));
    nrd = rd_cnt - base;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R11 free after take", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
  endtask

  task automatic t_basic;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    logic [GOFS_W-1:0] o;
    o = (40'd3 << 21) | 40'h1ABCD;
    mem_img[RBASE + 37'd20] = root_ent(21'h12, 1'b1);
    mem_img[exp_leaf(21'h12, o)] = leaf_ent(16'h777, 1'b1);
    do_req(6'd5, o, c, h, n);
    chk(n == 2, "R4 two reads", 64'(n), 64'd2);
    chk(rd_log[(rd_cnt - 2) % 16] == RBASE + 37'd20, "R2 root address",
        64'(rd_log[(rd_cnt - 2) % 16]), 64'(RBASE + 37'd20));
    chk(rd_log[(rd_cnt - 1) % 16] == exp_leaf(21'h12, o), "R3 leaf address",
        64'(rd_log[(rd_cnt - 1) % 16]), 64'(exp_leaf(21'h12, o)));
    chk(c == 3'd0, "R4 code", 64'(c), 64'd0);
    chk(h == ((37'h777 << 21) | 37'h1ABCD), "R4 host address", 64'(h),
        64'((37'h777 << 21) | 37'h1ABCD));
  endtask

  task automatic t_reserved_max;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    logic [GOFS_W-1:0] o;
    o = 40'h1F_FFFF_FFFF;
    mem_img[RBASE + 37'd252] = 32'hFE00_000E | root_ent(21'h1FFF00, 1'b1);
    mem_img[exp_leaf(21'h1FFF00, o)] = 32'hFFE0_001E | leaf_ent(16'hFFFF, 1'b1);
    do_req(6'd63, o, c, h, n);
    chk(rd_log[(rd_cnt - 2) % 16] == RBASE + 37'd252, "R2 top function",
        64'(rd_log[(rd_cnt - 2) % 16]), 64'(RBASE + 37'd252));
    chk(rd_log[(rd_cnt - 1) % 16] == 37'h1F_FF03_FFFC, "R3 R10 top index, reserved ones",
        64'(rd_log[(rd_cnt - 1) % 16]), 64'h1F_FF03_FFFC);
    chk(c == 3'd0 && h == 37'h1F_FFFF_FFFF, "R10 R4 reserved ignored", 64'(h), 64'h1F_FFFF_FFFF);
  endtask

  task automatic t_fid0;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    do_req(6'd0, 40'h20_0000, c, h, n);
    chk(c == 3'd2, "R5 function 0 code", 64'(c), 64'd2);
    chk(n == 0, "R5 no read", 64'(n), 64'd0);
    chk(h == '0, "R9 zero address", 64'(h), 64'd0);
  endtask

  task automatic t_range;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    do_req(6'd0, 40'h20_0000_0000, c, h, n);
    chk(c == 3'd1, "R6 range precedes function 0", 64'(c), 64'd1);
    chk(n == 0, "R6 no read", 64'(n), 64'd0);
    do_req(6'd5, 40'h80_0000_0000, c, h, n);
    chk(c == 3'd1 && n == 0, "R6 top bit", 64'(c), 64'd1);
  endtask

  task automatic t_root_inv;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    mem_img[RBASE + 37'd36] = root_ent(21'h40, 1'b0);
    do_req(6'd9, 40'h0, c, h, n);
    chk(c == 3'd3, "R7 root invalid code", 64'(c), 64'd3);
    chk(n == 1, "R7 single read", 64'(n), 64'd1);
    chk(h == '0, "R9 zero address", 64'(h), 64'd0);
  endtask

  task automatic t_leaf_inv;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    logic [GOFS_W-1:0] o;
    o = (40'd7 << 21) | 40'h55;
    mem_img[RBASE + 37'd40] = root_ent(21'h80, 1'b1);
    mem_img[exp_leaf(21'h80, o)] = 32'hFFFF_FFFE;
    do_req(6'd10, o, c, h, n);
    chk(c == 3'd4, "R8 leaf invalid code", 64'(c), 64'd4);
    chk(n == 2, "R8 two reads", 64'(n), 64'd2);
    chk(h == '0, "R9 zero address", 64'(h), 64'd0);
  endtask

  task automatic t_remap;
    logic [2:0] c; logic [HAW-1:0] h; int n;
    logic [GOFS_W-1:0] o;
    o = (40'd3 << 21) | 40'h1ABCD;
    mem_img[RBASE + 37'd24] = root_ent(21'h300, 1'b1);
    mem_img[exp_leaf(21'h300, o)] = leaf_ent(16'h0042, 1'b1);
    do_req(6'd6, o, c, h, n);
    chk(rd_log[(rd_cnt - 1) % 16] == exp_leaf(21'h300, o), "R3 per-function table",
        64'(rd_log[(rd_cnt - 1) % 16]), 64'(exp_leaf(21'h300, o)));
    chk(c == 3'd0 && h == ((37'h42 << 21) | 37'h1ABCD), "R4 second function",
        64'(h), 64'((37'h42 << 21) | 37'h1ABCD));
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b0; req_fid = '0; req_gofs = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_reserved_max();
    t_fid0();
    t_range();
    t_root_inv();
    t_leaf_inv();
    t_remap();
    chk(mon_bad == 0, "R12 address held while waiting", 64'(mon_bad), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule